// File: doc/BRIEF.md
# Parametric Set-Associative L1 Cache

This block is a read/write first-level cache with a fixed 32-byte line, whose set count and associativity are compile-time power-of-two parameters. Each 32-bit request address is cut into a byte offset, a set index and a tag. The tags of every way in the indexed set are compared at once, and one cycle after acceptance the block reports hit or miss, the hitting way and the addressed 32-bit word.

The block does not fetch lines by itself. Every response also carries the replacement victim of the set just looked up, the way with the oldest recency rank. An external fill controller (in the bench, a memory model) reads this victim on a miss and installs a whole line into that way through a one-cycle fill port. The fill path therefore stays the same whatever the associativity. Replacement is true LRU, kept as a per-way age rank in each set. Write hits update one word in place. Write misses allocate nothing.

Top module: `l1_cache_core`

## Requirements
- R1: An address splits as byte offset addr[4:0], word select addr[4:2], set index addr[5+IW-1:5] and tag addr[31:5+IW], with IW = log2(SETS). Lines with the same index and different tags compete for the ways of one set. The same tag in a different set is a different line.
- R2: Reset (synchronous, active high) invalidates every way of every set, so every lookup after reset misses until a fill is made.
- R3: A request is accepted when req_valid is high and fill_valid is low. rsp_valid is high in exactly the following cycle, together with that request's rsp_hit, rsp_way and rsp_rdata.
- R4: rsp_hit is high only when a valid way of the indexed set holds the request's tag. rsp_way then gives that way's index.
- R5: A read hit returns, on rsp_rdata, the 32-bit word selected by addr[4:2]: bits [32*k+31:32*k] of the installed line for word k.
- R6: A write hit replaces the addressed word of the hitting way. A write miss changes no tag, valid bit, data or recency, so a later read of that address still misses.
- R7: A fill writes the tag, sets the valid bit and stores all eight words of fill_line into way fill_way of the set given by fill_addr, all in one cycle. It is visible to a request accepted in the next cycle.
- R8: rsp_victim gives the way holding the oldest rank in the set of the last accepted request. After reset, the ranks of each set are way index order, so the first victim is way WAYS-1. A way that was just filled is not the victim of a following miss to its set.
- R9: A hit or a fill on way k makes k the most recent. Every way that was more recent than k ages by one rank, and the others keep their rank. A hit way is never the reported victim.
- R10: A request presented while fill_valid is high is not accepted and produces no response. The fill still takes place.
- R11: With 128 sets, a working set that puts three lines in every set, accessed in a round-robin over the three lines, misses on every access at 2 ways. At 4 ways it hits on every access after the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | 1 = word write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write word |
| fill_valid | input | 1 | Install a line this cycle |
| fill_way | input | max(1,log2(WAYS)) | Way to install into |
| fill_addr | input | 32 | Any byte address inside the line being installed |
| fill_line | input | 256 | Line contents, word k at bits [32k+31:32k] |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_write | output | 1 | That request was a write |
| rsp_hit | output | 1 | Tag matched in a valid way |
| rsp_way | output | max(1,log2(WAYS)) | Hitting way |
| rsp_rdata | output | 32 | Addressed word of the hitting line |
| rsp_victim | output | max(1,log2(WAYS)) | Replacement victim of the looked-up set |

## Verification
A corrupted valid bit or tag shows one cycle after the next request to that set, as a wrong rsp_hit or rsp_way. A corrupted recency rank does not show at once. It shows on rsp_victim at the next lookup of the set, and as a wrong eviction only after a later fill, so the bench checks the victim on every response and replays miss-and-fill sequences. Data bank faults appear only on read hits, so word selection is exercised over several offsets and after in-place writes.

// File: rtl/l1c_pkg.sv
`timescale 1ns/1ps
package l1c_pkg;
  localparam int ADDR_W     = 32;
  localparam int OFF_W      = 5;
  localparam int LINE_WORDS = 8;
  localparam int WORD_W     = 32;
  localparam int LINE_W     = LINE_WORDS * WORD_W;

  function automatic int log2_min1(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/l1c_tag_store.sv
`timescale 1ns/1ps
module l1c_tag_store #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  parameter int IW   = 7,
  parameter int TW   = 20,
  parameter int WW   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   rd_idx,
  input  logic [TW-1:0]   rd_tag,
  output logic [WAYS-1:0] hit_vec,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [WW-1:0]   wr_way,
  input  logic [TW-1:0]   wr_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TW-1:0]   tag_mem [SETS];
    logic [SETS-1:0] vld;
    logic            sel;

    assign sel = wr_en && (wr_way == WW'(w));

    always_ff @(posedge clk) begin
      if (rst) vld <= '0;
      else if (sel) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) tag_mem[wr_idx] <= wr_tag;
    end

    assign hit_vec[w] = vld[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  end
endmodule

// File: rtl/l1c_line_store.sv
`timescale 1ns/1ps
module l1c_line_store
  import l1c_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  parameter int IW   = 7,
  parameter int WW   = 1
) (
  input  logic              clk,
  input  logic [IW-1:0]     rd_idx,
  input  logic [2:0]        rd_word,
  output logic [WORD_W-1:0] way_word [WAYS],
  input  logic              fill_en,
  input  logic [IW-1:0]     fill_idx,
  input  logic [WW-1:0]     fill_way,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WW-1:0]     wr_way,
  input  logic [2:0]        wr_word,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] bank_q [WAYS][LINE_WORDS];
  logic [2:0]        word_q;

  always_ff @(posedge clk) word_q <= rd_word;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
      logic [WORD_W-1:0] mem [SETS];
      logic [WORD_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (fill_en && fill_way == WW'(w))
          mem[fill_idx] <= fill_line[b*WORD_W +: WORD_W];
        else if (wr_en && wr_way == WW'(w) && wr_word == 3'(b))
          mem[wr_idx] <= wr_data;
        rd_q <= mem[rd_idx];
      end

      assign bank_q[w][b] = rd_q;
    end
    assign way_word[w] = bank_q[w][word_q];
  end
endmodule

// File: rtl/l1c_age_lru.sv
`timescale 1ns/1ps
module l1c_age_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  parameter int IW   = 7,
  parameter int WW   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [WW-1:0] touch_way,
  input  logic [IW-1:0] look_idx,
  output logic [WW-1:0] victim
);
  localparam logic [WW-1:0] OLDEST = WW'(WAYS - 1);

  logic [WW-1:0] age [SETS][WAYS];
  logic [WW-1:0] ref_age;

  assign ref_age = age[touch_idx][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WW'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == touch_way)
          age[touch_idx][w] <= '0;
        else if (age[touch_idx][w] < ref_age)
          age[touch_idx][w] <= age[touch_idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[look_idx][w] == OLDEST) victim = WW'(w);
  end
endmodule

// File: rtl/l1_cache_core.sv
`timescale 1ns/1ps
module l1_cache_core
  import l1c_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int IW  = log2_min1(SETS),
  localparam int WW  = log2_min1(WAYS),
  localparam int TW  = ADDR_W - OFF_W - IW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              fill_valid,
  input  logic [WW-1:0]     fill_way,
  input  logic [31:0]       fill_addr,
  input  logic [LINE_W-1:0] fill_line,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_hit,
  output logic [WW-1:0]     rsp_way,
  output logic [31:0]       rsp_rdata,
  output logic [WW-1:0]     rsp_victim
);
  logic [IW-1:0]     req_idx, fill_idx, idx_q;
  logic [TW-1:0]     req_tag, fill_tag;
  logic [2:0]        req_word;
  logic              accept, hit_any, touch_en;
  logic [WAYS-1:0]   hit_vec;
  logic [WW-1:0]     hit_way;
  logic [WORD_W-1:0] way_word [WAYS];
  logic              unused_bits;

  assign req_word = req_addr[4:2];
  assign req_idx  = req_addr[OFF_W +: IW];
  assign req_tag  = req_addr[ADDR_W-1 -: TW];
  assign fill_idx = fill_addr[OFF_W +: IW];
  assign fill_tag = fill_addr[ADDR_W-1 -: TW];
  assign unused_bits = ^{req_addr[1:0], fill_addr[OFF_W-1:0]};

  assign accept = req_valid && !fill_valid;

  l1c_tag_store #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .TW(TW), .WW(WW)) tags_i (
    .clk(clk), .rst(rst),
    .rd_idx(req_idx), .rd_tag(req_tag), .hit_vec(hit_vec),
    .wr_en(fill_valid), .wr_idx(fill_idx), .wr_way(fill_way), .wr_tag(fill_tag)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WW'(w);
  end
  assign hit_any = |hit_vec;

  l1c_line_store #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) data_i (
    .clk(clk),
    .rd_idx(req_idx), .rd_word(req_word), .way_word(way_word),
    .fill_en(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way), .fill_line(fill_line),
    .wr_en(accept && req_write && hit_any), .wr_idx(req_idx), .wr_way(hit_way),
    .wr_word(req_word), .wr_data(req_wdata)
  );

  assign touch_en = fill_valid || (accept && hit_any);

  l1c_age_lru #(.SETS(SETS), .WAYS(WAYS), .IW(IW), .WW(WW)) lru_i (
    .clk(clk), .rst(rst),
    .touch_en(touch_en),
    .touch_idx(fill_valid ? fill_idx : req_idx),
    .touch_way(fill_valid ? fill_way : hit_way),
    .look_idx(idx_q), .victim(rsp_victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      idx_q     <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_write <= req_write;
        rsp_hit   <= hit_any;
        rsp_way   <= hit_way;
        idx_q     <= req_idx;
      end
    end
  end

  assign rsp_rdata = way_word[rsp_way];
endmodule

// File: rtl/l1c_checker.sv
`timescale 1ns/1ps
module l1c_checker
  import l1c_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int IW  = log2_min1(SETS),
  localparam int WW  = log2_min1(WAYS)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [31:0]   req_addr,
  input logic          fill_valid,
  input logic [WW-1:0] fill_way,
  input logic [31:0]   fill_addr,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [WW-1:0] rsp_way,
  input logic [WW-1:0] rsp_victim
);
  logic unused_bits;
  assign unused_bits = ^{req_addr, fill_addr};

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid)) else $error("rsp without request"); // R3

  AST_FILL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    $past(fill_valid) |-> !rsp_valid) else $error("request taken during fill"); // R10

  AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
    (WAYS > 1 && rsp_valid && rsp_hit) |-> (rsp_victim != rsp_way))
    else $error("hit way left oldest"); // R9

  AST_FILL_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
    (WAYS > 1 && rsp_valid && !rsp_hit && $past(fill_valid, 2) &&
     $past(fill_addr[OFF_W +: IW], 2) == $past(req_addr[OFF_W +: IW]))
    |-> (rsp_victim != $past(fill_way, 2)))
    else $error("fresh fill chosen as victim"); // R8
endmodule

bind l1_cache_core l1c_checker #(.SETS(SETS), .WAYS(WAYS)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .fill_valid(fill_valid), .fill_way(fill_way), .fill_addr(fill_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim)
);

// File: tb/l1_cache_core_tb_top.sv
`timescale 1ns/1ps
module l1_cache_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         req_valid = 0, req_write = 0;
  logic [31:0]  req_addr = 0, req_wdata = 0;
  logic         fv2 = 0, fv4 = 0;
  logic         fw2 = 0;
  logic [1:0]   fw4 = 0;
  logic [31:0]  fill_addr = 0;
  logic [255:0] fill_line = 0;

  logic        v2, wr2, h2; logic w2, vic2; logic [31:0] d2;
  logic        v4, wr4, h4; logic [1:0] w4, vic4; logic [31:0] d4;

  l1_cache_core #(.SETS(128), .WAYS(2)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .fill_valid(fv2), .fill_way(fw2),
    .fill_addr(fill_addr), .fill_line(fill_line), .rsp_valid(v2), .rsp_write(wr2),
    .rsp_hit(h2), .rsp_way(w2), .rsp_rdata(d2), .rsp_victim(vic2));

  l1_cache_core #(.SETS(128), .WAYS(4)) dut4_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .fill_valid(fv4), .fill_way(fw4),
    .fill_addr(fill_addr), .fill_line(fill_line), .rsp_valid(v4), .rsp_write(wr4),
    .rsp_hit(h4), .rsp_way(w4), .rsp_rdata(d4), .rsp_victim(vic4));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] pat(input logic [31:0] a, input int k);
    return {a[31:5], 5'b0} ^ (32'h0101_0101 * (k + 1)) ^ 32'hA500_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_fill(input logic [31:0] a, input bit e2, input bit way2,
                         input bit e4, input logic [1:0] way4);
    @(negedge clk);
    fill_addr = a;
    for (int k = 0; k < 8; k++) fill_line[k*32 +: 32] = pat(a, k);
    fv2 = e2; fw2 = way2; fv4 = e4; fw4 = way4;
    @(negedge clk);
    fv2 = 0; fv4 = 0;
  endtask

  typedef struct packed {
    logic [1:0]  op;    // 0 read, 1 write, 2 fill
    logic [1:0]  way;
    logic [31:0] addr;
    logic [31:0] data;
    logic        ehit;
    logic [1:0]  eway;
    logic        epat;
    logic [1:0]  evict;
  } vec_t;

  localparam vec_t VT [16] = '{
    '{2'd0, 2'd0, 32'h0000_1060, 32'h0,         1'b0, 2'd0, 1'b0, 2'd1},
    '{2'd2, 2'd1, 32'h0000_1060, 32'h0,         1'b0, 2'd0, 1'b0, 2'd0},
    '{2'd0, 2'd0, 32'h0000_1068, 32'h0,         1'b1, 2'd1, 1'b1, 2'd0},
    '{2'd0, 2'd0, 32'h0000_2060, 32'h0,         1'b0, 2'd0, 1'b0, 2'd0},
    '{2'd2, 2'd0, 32'h0000_2060, 32'h0,         1'b0, 2'd0, 1'b0, 2'd0},
    '{2'd0, 2'd0, 32'h0000_2064, 32'h0,         1'b1, 2'd0, 1'b1, 2'd1},
    '{2'd0, 2'd0, 32'h0000_107C, 32'h0,         1'b1, 2'd1, 1'b1, 2'd0},
    '{2'd1, 2'd0, 32'h0000_1064, 32'hDEAD_BEEF, 1'b1, 2'd1, 1'b0, 2'd0},
    '{2'd0, 2'd0, 32'h0000_1064, 32'hDEAD_BEEF, 1'b1, 2'd1, 1'b0, 2'd0},
    '{2'd1, 2'd0, 32'h0000_3064, 32'h1234_5678, 1'b0, 2'd0, 1'b0, 2'd0},
    '{2'd0, 2'd0, 32'h0000_3064, 32'h0,         1'b0, 2'd0, 1'b0, 2'd0},
    '{2'd2, 2'd0, 32'h0000_3060, 32'h0,         1'b0, 2'd0, 1'b0, 2'd0},
    '{2'd0, 2'd0, 32'h0000_2060, 32'h0,         1'b0, 2'd0, 1'b0, 2'd1},
    '{2'd0, 2'd0, 32'h0000_3068, 32'h0,         1'b1, 2'd0, 1'b1, 2'd1},
    '{2'd0, 2'd0, 32'h0000_1064, 32'hDEAD_BEEF, 1'b1, 2'd1, 1'b0, 2'd0},
    '{2'd0, 2'd0, 32'h0000_1080, 32'h0,         1'b0, 2'd0, 1'b0, 2'd1}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hits2, miss4, bad4;
    repeat (3) @(negedge clk);
    chk(v2 == 0 && h2 == 0, "R2", "rsp_valid/hit in reset", {v2, h2}, 0);
    rst = 0;
    @(negedge clk);
    chk(vic2 == 1'b1, "R8", "reset victim", 32'(vic2), 1);

    // table walk on the 2-way cache: R1 R4 R5 R6 R7 R8 R9
    foreach (VT[i]) begin
      if (VT[i].op == 2) begin
        do_fill(VT[i].addr, 1, VT[i].way[0], 0, 0);
      end else begin
        do_req(VT[i].op == 1, VT[i].addr, VT[i].data);
        chk(v2 == 1, "R3", $sformatf("vec%0d rsp_valid", i), 32'(v2), 1);
        chk(h2 == VT[i].ehit, "R4", $sformatf("vec%0d hit", i), 32'(h2), 32'(VT[i].ehit));
        if (VT[i].ehit)
          chk(w2 == VT[i].eway[0], "R4", $sformatf("vec%0d way", i), 32'(w2), 32'(VT[i].eway));
        if (VT[i].ehit && VT[i].op == 0)
          chk(d2 == (VT[i].epat ? pat(VT[i].addr, int'(VT[i].addr[4:2])) : VT[i].data),
              "R5", $sformatf("vec%0d rdata", i), d2,
              VT[i].epat ? pat(VT[i].addr, int'(VT[i].addr[4:2])) : VT[i].data);
        chk(vic2 == VT[i].evict[0], "R8", $sformatf("vec%0d victim", i), 32'(vic2), 32'(VT[i].evict));
      end
    end

    // R3: response lasts exactly one cycle
    do_req(0, 32'h0000_1060, 0);
    @(negedge clk);
    chk(v2 == 0, "R3", "rsp_valid drops", 32'(v2), 0);

    // R10: request during fill is dropped, fill lands
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_1060;
    fill_addr = 32'h0000_5100;
    for (int k = 0; k < 8; k++) fill_line[k*32 +: 32] = pat(32'h0000_5100, k);
    fv2 = 1; fw2 = 0;
    @(negedge clk);
    req_valid = 0; fv2 = 0;
    chk(v2 == 0, "R10", "no response during fill", 32'(v2), 0);
    do_req(0, 32'h0000_5108, 0);
    chk(h2 == 1 && w2 == 0, "R7", "fill visible", {h2, w2}, 32'h2);
    chk(d2 == pat(32'h0000_5100, 2), "R7", "fill word2", d2, pat(32'h0000_5100, 2));

    // R2: reset invalidates installed lines
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    do_req(0, 32'h0000_1060, 0);
    chk(h2 == 0, "R2", "miss after reset", 32'(h2), 0);
    chk(vic2 == 1, "R8", "victim after reset", 32'(vic2), 1);

    // R11: three lines per set over all 128 sets, round robin
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    hits2 = 0; miss4 = 0; bad4 = 0;
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 3; l++)
        for (int s = 0; s < 128; s++) begin
          logic [31:0] a;
          bit m2, m4;
          logic [1:0] vc4;
          bit vc2;
          a = 32'((l + 1) << 12) | 32'(s << 5) | 32'(l << 2);
          do_req(0, a, 0);
          m2 = !h2; m4 = !h4; vc2 = vic2; vc4 = vic4;
          if (p > 0 && h2) hits2++;
          if (p > 0 && !h4) miss4++;
          if (h4 && d4 != pat(a, l)) bad4++;
          if (m2 || m4) do_fill(a, m2, vc2, m4, vc4);
        end
    chk(hits2 == 0, "R11", "2-way hits after warm-up", 32'(hits2), 0);
    chk(miss4 == 0, "R11", "4-way misses after warm-up", 32'(miss4), 0);
    chk(bad4 == 0, "R11", "4-way hit data errors", 32'(bad4), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule